// File: doc/BRIEF.md
# Six-Operation Decode and Execute Core

This block is the decode, register-file and arithmetic part of a small 32-bit single-cycle processor. A fetch stage outside the block presents an instruction word. On each rising clock edge the core captures that word and reads its three register operands from a 32-entry by 32-bit register file. During the cycle that follows it decodes the word and computes a result. It also drives a load or store request on a data memory port, or raises a branch-taken flag with a signed offset for the fetch stage.

Results are written back to the register file on the falling edge of the same cycle. The instruction that follows therefore reads the new value at its own rising edge, with no forwarding path. The external data memory is expected to answer a load combinationally from the address. It commits a store on the falling edge while the write strobe is high.

The first register field of every instruction names the destination, or the stored value for a store. The other two fields are sources. An opcode outside the six defined ones leaves every register, the memory port and the branch flag untouched.

Top module: `sixop_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, memory read, memory write and branch-taken are all low. Every register reads back as zero.
- R2: ADD (opcode 0 in bits 31:26) writes the sum of the registers named by bits 20:16 and bits 15:11 into the register named by bits 25:21, wrapping modulo 2^32.
- R3: SUB (opcode 1) writes the register named by bits 20:16 minus the register named by bits 15:11 into the register named by bits 25:21, wrapping modulo 2^32.
- R4: LW (opcode 2) raises memory read and drives the address as the register named by bits 20:16 plus bits 4:0 zero-extended. Bits 15:5 have no effect on the address. The returned data is written into the register named by bits 25:21.
- R5: SW (opcode 3) raises memory write, drives the address as in R4 and drives the write data with the register named by bits 25:21. No register is written.
- R6: BEQ (opcode 4) raises branch-taken exactly when the registers named by bits 25:21 and 20:16 are equal. The branch offset output is bits 15:0 sign-extended to 32 bits. No register or memory access takes place.
- R7: LI (opcode 5) writes bits 15:0 sign-extended to 32 bits into the register named by bits 25:21 and makes no memory access.
- R8: Operands are captured on the rising edge and the register write happens on the falling edge of the same cycle. An instruction that reads a register written by the instruction just before it sees the new value.
- R9: Any opcode from 6 to 63 writes no register, makes no memory access and raises no branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands captured on the rising edge, register writes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrWord | input | 32 | Instruction word from the fetch stage, sampled on the rising edge |
| memRData | input | 32 | Load data returned by the data memory for memAddr |
| memAddr | output | 32 | Data memory word address for a load or store |
| memRead | output | 1 | Load request strobe |
| memWrite | output | 1 | Store request strobe, committed by the memory on the falling edge |
| memWData | output | 32 | Store data |
| branchTaken | output | 1 | High when an equal-compare branch is taken |
| branchOffset | output | 32 | Sign-extended branch offset for the fetch stage |

## Verification
The assertions assume that instrWord is stable around each rising edge. They also assume that memRData settles from memAddr before the falling edge, so that a load writes back a defined word. The bench changes the instruction only just after a falling edge and serves loads from a combinational array indexed by the low address bits. The same array commits stores at the falling edge, as the port contract requires. Register contents are never read from inside the block: every register value is brought out by a store and compared at the write-data and address pins against a model the bench keeps of its own.

// File: rtl/sixop_pkg.sv
package sixop_pkg;

  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int IDX_W    = 5;
  localparam int IMM_W    = 16;
  localparam int OPC_LSB  = 26;
  localparam int DST_LSB  = 21;
  localparam int SRCA_LSB = 16;
  localparam int SRCB_LSB = 11;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 6'd0,
    OP_SUB = 6'd1,
    OP_LW  = 6'd2,
    OP_SW  = 6'd3,
    OP_BEQ = 6'd4,
    OP_LI  = 6'd5
  } opcode_e;

  localparam logic [OPC_W-1:0] OP_IDLE = 6'h3F;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
    logic immToReg;
    logic memRead;
    logic memWrite;
    logic isBranch;
    logic aluSub;
  } ctlStrobes_t;

endpackage

// File: rtl/sixop_regfile.sv
module sixop_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  parameter int NUM_RD  = 3,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rdAddr [NUM_RD],
  output logic [DATA_W-1:0] rdData [NUM_RD],
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] regs [REG_CNT];

  // storage is updated on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[wrAddr] <= wrData;
    end
  end

  // each read port captures its operand on the rising edge
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdData[p] <= '0;
      else        rdData[p] <= regs[rdAddr[p]];
    end
  end

endmodule

// File: rtl/sixop_ctrl.sv
module sixop_ctrl
  import sixop_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctlStrobes_t      ctl
);

  always_comb begin
    ctl = '0;
    case (opcode)
      OP_ADD: ctl.regWrite = 1'b1;
      OP_SUB: begin
        ctl.regWrite = 1'b1;
        ctl.aluSub   = 1'b1;
      end
      OP_LW: begin
        ctl.regWrite = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.memRead  = 1'b1;
      end
      OP_SW:  ctl.memWrite = 1'b1;
      OP_BEQ: ctl.isBranch = 1'b1;
      OP_LI: begin
        ctl.regWrite = 1'b1;
        ctl.immToReg = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/sixop_datapath.sv
module sixop_datapath
  import sixop_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT),
  localparam int EXT_W  = DATA_W - IMM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instrWord,
  input  ctlStrobes_t        ctl,
  output logic [OPC_W-1:0]   opcode,
  input  logic [DATA_W-1:0]  memRData,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWData,
  output logic               branchTaken,
  output logic [DATA_W-1:0]  branchOffset
);

  logic [INSTR_W-1:0] instrQ;
  logic [ADDR_W-1:0]  rdSel [3];
  logic [DATA_W-1:0]  rdVal [3];
  logic [DATA_W-1:0]  dstVal, srcAVal, srcBVal;
  logic [DATA_W-1:0]  opB, aluOut, immExt, wbData;

  // instruction captured together with the operands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) instrQ <= {OP_IDLE, {(INSTR_W-OPC_W){1'b0}}};
    else        instrQ <= instrWord;
  end

  assign opcode = instrQ[OPC_LSB +: OPC_W];

  // operand selection uses the incoming word so that reads align with capture
  assign rdSel[0] = instrWord[DST_LSB  +: ADDR_W];
  assign rdSel[1] = instrWord[SRCA_LSB +: ADDR_W];
  assign rdSel[2] = instrWord[SRCB_LSB +: ADDR_W];

  sixop_regfile #(
    .DATA_W (DATA_W),
    .REG_CNT(REG_CNT),
    .NUM_RD (3)
  ) regfile_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rdAddr(rdSel),
    .rdData(rdVal),
    .wrEn  (ctl.regWrite),
    .wrAddr(instrQ[DST_LSB +: ADDR_W]),
    .wrData(wbData)
  );

  assign dstVal  = rdVal[0];
  assign srcAVal = rdVal[1];
  assign srcBVal = rdVal[2];

  // add or subtract by inverting and carrying in
  assign opB    = srcBVal ^ {DATA_W{ctl.aluSub}};
  assign aluOut = srcAVal + opB + DATA_W'(ctl.aluSub);

  assign immExt = {{EXT_W{instrQ[IMM_W-1]}}, instrQ[IMM_W-1:0]};

  assign memAddr      = srcAVal + DATA_W'(instrQ[IDX_W-1:0]);
  assign memWData     = dstVal;
  assign branchTaken  = ctl.isBranch && (dstVal == srcAVal);
  assign branchOffset = immExt;

  always_comb begin
    if (ctl.immToReg)      wbData = immExt;
    else if (ctl.memToReg) wbData = memRData;
    else                   wbData = aluOut;
  end

  // R6
  branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branchTaken |-> (!ctl.memRead && !ctl.memWrite && !ctl.regWrite));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.memWrite |-> (!ctl.regWrite && !ctl.memRead));

  // R4
  load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.memRead |-> (ctl.regWrite && wbData == memRData));

  // R3
  alu_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.regWrite && !ctl.memToReg && !ctl.immToReg) |->
      (ctl.aluSub ? (aluOut + srcBVal == srcAVal) : (aluOut - srcBVal == srcAVal)));

  // R7
  imm_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.immToReg |-> (wbData[DATA_W-1:IMM_W] == {EXT_W{wbData[IMM_W-1]}}));

endmodule

// File: rtl/sixop_core.sv
module sixop_core
  import sixop_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  memRData,
  output logic [DATA_W-1:0]  memAddr,
  output logic               memRead,
  output logic               memWrite,
  output logic [DATA_W-1:0]  memWData,
  output logic               branchTaken,
  output logic [DATA_W-1:0]  branchOffset
);

  ctlStrobes_t      ctl;
  logic [OPC_W-1:0] opcode;

  sixop_ctrl ctrl_i (
    .opcode(opcode),
    .ctl   (ctl)
  );

  sixop_datapath #(
    .DATA_W (DATA_W),
    .REG_CNT(REG_CNT)
  ) datapath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instrWord   (instrWord),
    .ctl         (ctl),
    .opcode      (opcode),
    .memRData    (memRData),
    .memAddr     (memAddr),
    .memWData    (memWData),
    .branchTaken (branchTaken),
    .branchOffset(branchOffset)
  );

  assign memRead  = ctl.memRead;
  assign memWrite = ctl.memWrite;

  // R9
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode > OP_LI) |-> (!memRead && !memWrite && !branchTaken));

endmodule

// File: tb/sixop_core_tb_top.sv
`timescale 1ns/100ps
module sixop_core_tb_top;
  import sixop_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instrWord = 32'hFC00_0000;
  logic [31:0] memRData, memAddr, memWData, branchOffset;
  logic        memRead, memWrite, branchTaken;

  logic [31:0] mem    [64];
  logic [31:0] expMem [64];
  logic [31:0] sh     [32];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign memRData = mem[memAddr[5:0]];

  sixop_core dut_i (
    .clk(clk), .rst_n(rst_n), .instrWord(instrWord), .memRData(memRData),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite),
    .memWData(memWData), .branchTaken(branchTaken), .branchOffset(branchOffset)
  );

  function automatic logic [31:0] rtype(opcode_e op, int d, int a, int b);
    return {op, 5'(d), 5'(a), 5'(b), 11'd0};
  endfunction

  function automatic logic [31:0] itype(opcode_e op, int d, int a, logic [15:0] low);
    return {op, 5'(d), 5'(a), low};
  endfunction

  function automatic logic [31:0] sx16(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] pat(int k);
    return 32'h9E37_79B9 * 32'(k + 1);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one instruction: store commit of the previous one, then present and capture
  task automatic exec(logic [31:0] w);
    @(negedge clk);
    if (memWrite === 1'b1) mem[memAddr[5:0]] = memWData;
    #0.5 instrWord = w;
    @(posedge clk);
    #1;
  endtask

  // bring a register out through a store
  task automatic checkReg(int r, string req);
    int a;
    a = (r + 1) % 32;
    exec(itype(OP_SW, r, a, 16'(r)));
    chk(req, "store strobe", 32'(memWrite), 32'd1);
    chk(req, $sformatf("r%0d value", r), memWData, sh[r]);
    chk("R5", "store address", memAddr, sh[a] + 32'(r));
    expMem[(sh[a] + 32'(r)) & 32'd63] = sh[r];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] imm;
    logic [31:0] a32;
    for (int k = 0; k < 64; k++) begin
      mem[k] = pat(k);
      expMem[k] = pat(k);
    end
    for (int r = 0; r < 32; r++) sh[r] = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "strobes in reset", {29'd0, memRead, memWrite, branchTaken}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "strobes after reset", {29'd0, memRead, memWrite, branchTaken}, 32'd0);
    for (int r = 0; r < 32; r++) checkReg(r, "R1");

    // R7: load-immediate into every register, positive and negative values
    for (int r = 0; r < 32; r++) begin
      imm = 16'(r * 16'h1357) ^ 16'h8421;
      exec(itype(OP_LI, r, 0, imm));
      chk("R7", "no memory access", {30'd0, memRead, memWrite}, 32'd0);
      sh[r] = sx16(imm);
    end
    for (int r = 0; r < 32; r++) checkReg(r, "R7");

    // R8: back-to-back dependency across the edge split
    exec(itype(OP_LI, 1, 0, 16'd7));
    sh[1] = 32'd7;
    exec(rtype(OP_ADD, 2, 1, 1));
    sh[2] = 32'd14;
    checkReg(2, "R8");

    // R2: add sweep
    for (int i = 0; i < 32; i++) begin
      exec(rtype(OP_ADD, i, (i + 3) % 32, (i + 7) % 32));
      sh[i] = sh[(i + 3) % 32] + sh[(i + 7) % 32];
      checkReg(i, "R2");
    end

    // R3: subtract sweep
    for (int i = 0; i < 32; i++) begin
      exec(rtype(OP_SUB, i, (i + 5) % 32, (i + 11) % 32));
      sh[i] = sh[(i + 5) % 32] - sh[(i + 11) % 32];
      checkReg(i, "R3");
    end

    // R4: load with every index value
    exec(itype(OP_LI, 5, 0, 16'd2));
    sh[5] = 32'd2;
    for (int idx = 0; idx < 32; idx++) begin
      exec(itype(OP_LW, 9, 5, 16'(idx)));
      chk("R4", "load strobe", {30'd0, memRead, memWrite}, 32'd2);
      chk("R4", "load address", memAddr, 32'(2 + idx));
      sh[9] = expMem[2 + idx];
      checkReg(9, "R4");
    end
    // R4: bits 15:5 do not reach the address
    exec(itype(OP_LW, 9, 5, 16'hFFE3));
    chk("R4", "upper index bits ignored", memAddr, 32'd5);
    sh[9] = expMem[5];
    checkReg(9, "R4");

    // R6: branch compare
    exec(itype(OP_LI, 11, 0, 16'd5));
    sh[11] = 32'd5;
    exec(itype(OP_LI, 12, 0, 16'd5));
    sh[12] = 32'd5;
    exec(itype(OP_LI, 13, 0, 16'd6));
    sh[13] = 32'd6;
    exec(itype(OP_BEQ, 11, 12, 16'hFFF0));
    chk("R6", "taken on equal", 32'(branchTaken), 32'd1);
    chk("R6", "negative offset", branchOffset, 32'hFFFF_FFF0);
    chk("R6", "no memory access", {30'd0, memRead, memWrite}, 32'd0);
    exec(itype(OP_BEQ, 11, 13, 16'h0010));
    chk("R6", "not taken on unequal", 32'(branchTaken), 32'd0);
    chk("R6", "positive offset", branchOffset, 32'h0000_0010);
    exec(itype(OP_BEQ, 13, 13, 16'h7FFF));
    chk("R6", "taken on same register", 32'(branchTaken), 32'd1);
    checkReg(11, "R6");
    checkReg(13, "R6");

    // R9: every undefined opcode
    for (int op = 6; op < 64; op++) begin
      exec({6'(op), 5'd14, 5'd15, 16'h1234});
      chk("R9", $sformatf("opcode %0d quiet", op),
          {29'd0, memRead, memWrite, branchTaken}, 32'd0);
    end
    for (int r = 0; r < 32; r++) checkReg(r, "R9");

    // a final load of an address written by a store above
    a32 = sh[6] + 32'd5;
    exec(itype(OP_LW, 20, 6, 16'd5));
    exec(itype(OP_LI, 21, 0, 16'd0));
    sh[21] = 32'd0;
    sh[20] = expMem[a32 & 32'd63];
    checkReg(20, "R4");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule